// File: doc/BRIEF.md
# Result Window Select and Saturation

This block reduces a 32-bit signed accumulated filter result to a 20-bit output word. It takes one of four overlapping 20-bit windows out of the wide result, either at a position named by a 2-bit select input or at a position found automatically from the magnitude of the result. A 2-bit mode then decides what happens to the window. It can be sent out raw on a short path. It can be sent out raw on the long path. It can be saturated at both signed limits. Or negatives can be forced to zero while large positives are still saturated.

Each accepted result carries its own configuration, sampled together with the valid strobe. Downstream logic sees a 20-bit word with its own valid strobe. The raw short path is 13 cycles faster than the other modes, so a chain of cascaded units can skip the output treatment without adding pipeline delay.

Top module: `result_window_sat`

## Requirements
- R1: With auto selection off, window code 0 takes result bits [31:12], code 1 takes [27:8], code 2 takes [23:4] and code 3 takes [19:0].
- R2: With auto selection on, the select input is ignored. The block uses the highest window code whose result bits above the window all equal the window's top bit. Code 0 always qualifies.
- R3: Mode 1 sends the selected window unchanged, with wrap-around when the result does not fit the window.
- R4: Mode 2 detects overflow when any result bit above the window differs from the window's top bit. On overflow it outputs 0x7FFFF if result bit 31 is 0 and 0x80000 if it is 1. Without overflow it outputs the window.
- R5: Mode 3 outputs 0 when result bit 31 is 1. Otherwise it outputs 0x7FFFF on overflow and the window when there is no overflow.
- R6: Mode 0 sends the window unchanged on a path of one register: the output and its valid appear after the first clock edge that samples the input.
- R7: Modes 1 to 3 deliver the output and its valid after 14 clock edges, 13 more than mode 0.
- R8: When a mode 0 item and an earlier item from another mode reach the output in the same cycle, the earlier item is delivered and the mode 0 item is dropped.
- R9: While out_valid_o is low, out_data_o is zero. Both outputs are zero during and right after reset.
- R10: Select, auto and mode are sampled per valid item, so consecutive items may use different settings without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Result strobe |
| res_i | input | 32 | Signed accumulated result |
| auto_sel_i | input | 1 | 1: window chosen from the result magnitude |
| win_sel_i | input | 2 | Window code when auto selection is off |
| mode_i | input | 2 | 0 raw short path, 1 raw, 2 two-sided saturation, 3 negatives to zero |
| out_valid_o | output | 1 | Output strobe |
| out_data_o | output | 20 | Output word |

## Verification
The bench drives values sign-extended from every width between 1 and 32 bits, so each window sits right at its fit boundary. A wrong fit test would pick a window one step too narrow and wrap, or one step too wide and lose precision. Overflow is driven at both signs in both saturating modes. A design that keyed saturation on the window's top bit rather than the result's sign would clamp to the wrong limit, and one that skipped the zero rule would let negatives through in mode 3. The bench also times a mode 0 item to collide with an earlier item on the long path, and switches mode between items placed back to back. Wrong latency or wrong priority then shows up as a missing, duplicated or misplaced word.

// File: rtl/rws_pkg.sv
package rws_pkg;
  typedef enum logic [1:0] {
    GM_RAW_FAST = 2'b00,
    GM_RAW      = 2'b01,
    GM_SAT      = 2'b10,
    GM_CLAMP0   = 2'b11
  } gain_mode_e;
endpackage

// File: rtl/rws_fit_scan.sv
module rws_fit_scan #(
  parameter int IN_W     = 32,
  parameter int OUT_W    = 20,
  parameter int WIN_N    = 4,
  parameter int WIN_STEP = 4,
  localparam int SEL_W   = $clog2(WIN_N)
) (
  input  logic [IN_W-1:0]  res_i,
  output logic [WIN_N-1:0] fits_o,
  output logic [SEL_W-1:0] auto_sel_o
);
  // a window fits when everything from its top bit upward is one sign run
  for (genvar k = 0; k < WIN_N; k++) begin : g_fit
    localparam int SH = (WIN_N - 1 - k) * WIN_STEP + OUT_W - 1;
    logic signed [IN_W-1:0] sh;
    assign sh        = $signed(res_i) >>> SH;
    assign fits_o[k] = (sh == '0) || (&sh);
  end

  // highest fitting code wins (lowest bit offset)
  always_comb begin
    auto_sel_o = '0;
    for (int k = 0; k < WIN_N; k++) begin
      if (fits_o[k]) auto_sel_o = SEL_W'(k);
    end
  end
endmodule

// File: rtl/rws_window_mux.sv
module rws_window_mux #(
  parameter int IN_W     = 32,
  parameter int OUT_W    = 20,
  parameter int WIN_N    = 4,
  parameter int WIN_STEP = 4,
  localparam int SEL_W   = $clog2(WIN_N)
) (
  input  logic [IN_W-1:0]  res_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [WIN_N-1:0] fits_i,
  output logic [OUT_W-1:0] win_o,
  output logic             ovf_o
);
  always_comb begin
    win_o = '0;
    ovf_o = 1'b0;
    for (int k = 0; k < WIN_N; k++) begin
      if (sel_i == SEL_W'(k)) begin
        win_o = res_i[(WIN_N-1-k)*WIN_STEP +: OUT_W];
        ovf_o = ~fits_i[k];
      end
    end
  end
endmodule

// File: rtl/rws_gain_clamp.sv
module rws_gain_clamp
  import rws_pkg::*;
#(
  parameter int OUT_W = 20
) (
  input  gain_mode_e       mode_i,
  input  logic [OUT_W-1:0] win_i,
  input  logic             ovf_i,
  input  logic             neg_i,
  output logic [OUT_W-1:0] data_o
);
  localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

  always_comb begin
    unique case (mode_i)
      GM_SAT:    data_o = ovf_i ? (neg_i ? NEG_LIM : POS_LIM) : win_i;
      GM_CLAMP0: data_o = neg_i ? '0 : (ovf_i ? POS_LIM : win_i);
      default:   data_o = win_i;
    endcase
  end
endmodule

// File: rtl/rws_delay_line.sv
module rws_delay_line #(
  parameter int W     = 20,
  parameter int DEPTH = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         v_i,
  input  logic [W-1:0] d_i,
  output logic         v_o,
  output logic [W-1:0] d_o
);
  logic [W-1:0]     d_q [DEPTH];
  logic [DEPTH-1:0] v_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[s] <= 1'b0;
          d_q[s] <= '0;
        end else begin
          v_q[s] <= v_i;
          d_q[s] <= v_i ? d_i : '0;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[s] <= 1'b0;
          d_q[s] <= '0;
        end else begin
          v_q[s] <= v_q[s-1];
          d_q[s] <= d_q[s-1];
        end
      end
    end
  end

  assign v_o = v_q[DEPTH-1];
  assign d_o = d_q[DEPTH-1];
endmodule

// File: rtl/result_window_sat.sv
module result_window_sat
  import rws_pkg::*;
#(
  parameter int IN_W       = 32,
  parameter int OUT_W      = 20,
  parameter int WIN_N      = 4,
  parameter int WIN_STEP   = 4,
  parameter int FAST_LAT   = 1,
  parameter int GAIN_EXTRA = 13,
  localparam int SEL_W     = $clog2(WIN_N),
  localparam int GAIN_LAT  = FAST_LAT + GAIN_EXTRA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_valid_i,
  input  logic [IN_W-1:0]  res_i,
  input  logic             auto_sel_i,
  input  logic [SEL_W-1:0] win_sel_i,
  input  logic [1:0]       mode_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_data_o
);
  logic [WIN_N-1:0] fits;
  logic [SEL_W-1:0] auto_code, sel_code;
  logic [OUT_W-1:0] win, gain_d, fast_d, slow_d;
  logic             win_ovf, fast_v, slow_v;
  gain_mode_e       mode;

  assign mode     = gain_mode_e'(mode_i);
  assign sel_code = auto_sel_i ? auto_code : win_sel_i;

  rws_fit_scan #(
    .IN_W(IN_W), .OUT_W(OUT_W), .WIN_N(WIN_N), .WIN_STEP(WIN_STEP)
  ) u_fit (
    .res_i      (res_i),
    .fits_o     (fits),
    .auto_sel_o (auto_code)
  );

  rws_window_mux #(
    .IN_W(IN_W), .OUT_W(OUT_W), .WIN_N(WIN_N), .WIN_STEP(WIN_STEP)
  ) u_win (
    .res_i  (res_i),
    .sel_i  (sel_code),
    .fits_i (fits),
    .win_o  (win),
    .ovf_o  (win_ovf)
  );

  rws_gain_clamp #(.OUT_W(OUT_W)) u_clamp (
    .mode_i (mode),
    .win_i  (win),
    .ovf_i  (win_ovf),
    .neg_i  (res_i[IN_W-1]),
    .data_o (gain_d)
  );

  rws_delay_line #(.W(OUT_W), .DEPTH(GAIN_LAT)) u_slow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (res_valid_i && (mode != GM_RAW_FAST)),
    .d_i    (gain_d),
    .v_o    (slow_v),
    .d_o    (slow_d)
  );

  rws_delay_line #(.W(OUT_W), .DEPTH(FAST_LAT)) u_fast (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (res_valid_i && (mode == GM_RAW_FAST)),
    .d_i    (win),
    .v_o    (fast_v),
    .d_o    (fast_d)
  );

  // older item on the long path has priority on a collision
  always_comb begin
    out_valid_o = slow_v | fast_v;
    if (slow_v)      out_data_o = slow_d;
    else if (fast_v) out_data_o = fast_d;
    else             out_data_o = '0;
  end
endmodule

// File: rtl/rws_checker.sv
module rws_checker #(
  parameter int OUT_W    = 20,
  parameter int GAIN_LAT = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             res_valid_i,
  input logic [1:0]       mode_i,
  input logic             auto_sel_i,
  input logic             win_ovf_i,
  input logic [OUT_W-1:0] gain_d_i,
  input logic             out_valid_i,
  input logic [OUT_W-1:0] out_data_i
);
  localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

  logic [GAIN_LAT-1:0] pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= {pend_q[GAIN_LAT-2:0], res_valid_i && (mode_i != 2'b00)};
  end

  assert_auto_fits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && auto_sel_i) |-> !win_ovf_i);

  assert_sat_limits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && mode_i == 2'b10 && win_ovf_i) |-> (gain_d_i == POS_LIM || gain_d_i == NEG_LIM));

  assert_clamp_nonneg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && mode_i == 2'b11) |-> !gain_d_i[OUT_W-1]);

  assert_fast_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && mode_i == 2'b00) |=> out_valid_i);

  assert_slow_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[GAIN_LAT-1] |-> out_valid_i);

  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_i |-> (out_data_i == '0));
endmodule

bind result_window_sat rws_checker #(.OUT_W(OUT_W), .GAIN_LAT(GAIN_LAT)) i_rws_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .res_valid_i (res_valid_i),
  .mode_i      (mode_i),
  .auto_sel_i  (auto_sel_i),
  .win_ovf_i   (win_ovf),
  .gain_d_i    (gain_d),
  .out_valid_i (out_valid_o),
  .out_data_i  (out_data_o)
);

// File: tb/test_result_window_sat.sv
`timescale 1ns/1ps
module test_result_window_sat;
  localparam int GL = 14;
  localparam int BL = 1;
  localparam int N  = 4096;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        res_valid_i = 1'b0;
  logic [31:0] res_i = '0;
  logic        auto_sel_i = 1'b0;
  logic [1:0]  win_sel_i = '0;
  logic [1:0]  mode_i = '0;
  logic        out_valid_o;
  logic [19:0] out_data_o;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  bit          gv [N];
  logic [19:0] gd [N];
  string       gt [N];
  bit          bv [N];
  logic [19:0] bd [N];
  string       bt [N];

  always #4 clk_i = ~clk_i;

  result_window_sat i_result_window_sat (
    .clk_i, .rst_ni, .res_valid_i, .res_i, .auto_sel_i, .win_sel_i, .mode_i,
    .out_valid_o, .out_data_o
  );

  function automatic bit fits(logic [31:0] r, int k);
    logic signed [31:0] s;
    s = $signed(r) >>> ((3 - k) * 4 + 19);
    return (s == 0) || (s == -1);
  endfunction

  function automatic logic [19:0] model(logic [31:0] r, logic [1:0] s, bit a, logic [1:0] m);
    int k = int'(s);
    logic [19:0] w;
    bit ovf, neg;
    if (a) begin
      k = 0;
      for (int j = 3; j >= 0; j--) if (fits(r, j)) begin k = j; break; end
    end
    w   = 20'(r >> ((3 - k) * 4));
    ovf = !fits(r, k);
    neg = r[31];
    case (m)
      2'b10:   return ovf ? (neg ? 20'h80000 : 20'h7FFFF) : w;
      2'b11:   return neg ? 20'h0 : (ovf ? 20'h7FFFF : w);
      default: return w;
    endcase
  endfunction

  task automatic check_now();
    bit          ev;
    logic [19:0] ed;
    string       tg;
    ev = gv[cyc] | bv[cyc];
    ed = gv[cyc] ? gd[cyc] : (bv[cyc] ? bd[cyc] : 20'h0);
    tg = gv[cyc] ? (bv[cyc] ? "R8" : gt[cyc]) : (bv[cyc] ? bt[cyc] : "R9");
    checks++;
    if (out_valid_o !== ev || out_data_o !== ed) begin
      fails++;
      $display("FAIL %s cycle %0d: valid/data %b/%h expected %b/%h", tg, cyc,
               out_valid_o, out_data_o, ev, ed);
    end
  endtask

  task automatic step(bit v, logic [31:0] r, logic [1:0] s, bit a, logic [1:0] m, string t);
    @(negedge clk_i);
    cyc++;
    check_now();
    res_valid_i = v; res_i = r; win_sel_i = s; auto_sel_i = a; mode_i = m;
    if (v) begin
      if (m == 2'b00) begin
        bv[cyc+BL] = 1; bd[cyc+BL] = model(r, s, a, m); bt[cyc+BL] = {t, " R6"};
      end else begin
        gv[cyc+GL] = 1; gd[cyc+GL] = model(r, s, a, m); gt[cyc+GL] = {t, " R7"};
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, $urandom, 2'(i), 0, 2'b01, "R9");
  endtask

  function automatic logic [31:0] rand_res();
    logic signed [31:0] t;
    int nb;
    nb = $urandom_range(1, 32);
    t  = $urandom;
    if (nb < 32) t = (t <<< (32 - nb)) >>> (32 - nb);
    return t;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5417));
    repeat (3) @(negedge clk_i);
    checks++;  // R9 reset state
    if (out_valid_o !== 1'b0 || out_data_o !== 20'h0) begin
      fails++;
      $display("FAIL R9 reset: valid/data %b/%h expected 0/00000", out_valid_o, out_data_o);
    end
    rst_ni = 1'b1;

    // R1 each window code, R3 wrap
    for (int k = 0; k < 4; k++) step(1, 32'hABCDE123, 2'(k), 0, 2'b01, "R1 R3");
    // R2 auto: select input ignored
    step(1, 32'h00012345, 2'b00, 1, 2'b01, "R2");
    step(1, 32'h70000000, 2'b11, 1, 2'b01, "R2");
    step(1, 32'hFFFFFFFB, 2'b00, 1, 2'b10, "R2");
    step(1, 32'h0007FFFF, 2'b01, 1, 2'b01, "R2");
    step(1, 32'h00080000, 2'b01, 1, 2'b01, "R2");
    // R4 two-sided saturation
    step(1, 32'h01000000, 2'b11, 0, 2'b10, "R4");
    step(1, 32'hF0000000, 2'b11, 0, 2'b10, "R4");
    step(1, 32'hF0000000, 2'b00, 0, 2'b10, "R4");
    step(1, 32'h00040000, 2'b11, 0, 2'b10, "R4");
    // R5 negatives to zero
    step(1, 32'hFFFFFFFF, 2'b11, 0, 2'b11, "R5");
    step(1, 32'h40000000, 2'b10, 0, 2'b11, "R5");
    step(1, 32'h00012345, 2'b11, 0, 2'b11, "R5");
    // R6 fast raw path with overflow wraps
    step(1, 32'h12345678, 2'b11, 0, 2'b00, "R6");
    step(1, 32'h80000001, 2'b00, 0, 2'b00, "R6");
    idle(16);
    // R8 collision: fast item lands together with earlier slow item
    step(1, 32'h00055555, 2'b11, 0, 2'b01, "R8");
    idle(12);
    step(1, 32'h000AAAAA, 2'b11, 0, 2'b00, "R8");
    idle(16);
    // R10 random per-item configuration
    for (int i = 0; i < 2000; i++) begin
      bit v;
      v = ($urandom_range(0, 9) < 7);
      step(v, rand_res(), 2'($urandom), 1'($urandom), 2'($urandom), "R10");
    end
    idle(20);
    done = 1;
    summary();
    $finish;
  end
endmodule